// File: doc/BRIEF.md
# Chained DMA Tag Walker

This block is the sequencer of one DMA channel. It reads 128-bit quadwords through a simple read port and presents each returned quadword once on an output stream. In normal mode it reads a programmed number of quadwords, starting at a programmed memory address. In chain mode it reads a 128-bit tag at the tag address and decodes it. It then moves the quadwords that the tag describes and works out where the next tag lies. The walk repeats until a tag ends the chain.

Call and return tags use a two-entry stack of saved addresses. A tag can ask the channel to pause after its data. When the start bit is set again, the walk resumes from the saved tag address with the stack intact. Tags can also set or clear a global priority-control flag. While that flag is set and the channel-enable input is low, the channel issues no reads. Software programs the channel through a write port that is honoured only while the sequencer is idle. Every register can be read back on output ports.

Top module: `dma_tag_walker`

## Requirements
- R1: After reset the control, memory-address, count, tag-address and both saved-address registers read zero. The priority-control flag is clear, and no read request, output beat, done or interrupt pulse is active.
- R2: A start in normal mode (control bits [3:2] not equal to 1) with a count of zero issues no read. It clears start (control bit 8), pulses done, and leaves the count at zero and the memory address unchanged.
- R3: A start in normal mode with a count of N reads N quadwords at the memory address, stepping by 16 bytes, and outputs each one once in order. Afterwards the memory address points just past the last quadword, the count is zero, start is clear and done pulses.
- R4: The register write selects are 0 control (keeps bits 8, 7, 6, 3:2 and 0), 1 memory address, 2 count (low 16 bits), 3 tag address, 4 first saved address, 5 second saved address and 6 the priority-control flag (bit 0). The address registers force their low four bits to zero.
- R5: In a tag, bits [15:0] hold the count, [27:26] the priority-control action, [30:28] the kind and bit 31 the pause request; bits [63:32] hold an address whose low four bits are ignored. The kind codes are 0 refe, 1 cnt, 2 next, 3 ref, 4 refs, 5 call, 6 ret and 7 end. For ref, refs and refe the data comes from the tag's address and the next tag is the quadword after the tag. For the other kinds the data follows the tag. After cnt the next tag follows that data; after next and call it is at the tag's address.
- R6: A call pushes the address just past its data into the first saved-address register and moves the old first entry to the second. A ret with a non-empty stack takes the next tag address from the first entry and moves the second entry up.
- R7: An end tag, a refe tag, or a ret with an empty stack finishes the chain after its data: start clears and done pulses. The tag address then holds the address of the next tag as defined in R5, where end and an empty-stack ret count as cnt.
- R8: A tag of another kind with the pause request set stops the walk after its data. The count reads zero, the memory address points past the data and the tag address points at the following tag. Start clears, and the interrupt output pulses if control bit 7 is set.
- R9: Setting start again after a pause resumes the chain at the saved tag address.
- R10: A tag whose action field is 3 sets the priority-control flag and one whose action is 2 clears it. While the flag is set and the channel-enable input is low, no new read is issued and the count and memory address hold.
- R11: Register writes are ignored while the sequencer is not idle.
- R12: With control bit 6 set, each tag quadword is output before its data, with the tag marker high. Data beats have the marker low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| chan_en_i | input | 1 | Channel enable under priority control |
| mem_req_o | output | 1 | Read request, one cycle per quadword |
| mem_addr_o | output | AW | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 128 | Read data |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | 128 | Output quadword |
| out_is_tag_o | output | 1 | Beat is a forwarded tag |
| done_o | output | 1 | Transfer finished pulse |
| irq_o | output | 1 | Pause interrupt pulse |
| ctrl_o | output | 32 | Control register |
| madr_o | output | AW | Memory address register |
| qwc_o | output | 16 | Count register |
| tadr_o | output | AW | Tag address register |
| asr0_o | output | AW | First saved address |
| asr1_o | output | AW | Second saved address |
| pce_o | output | 1 | Priority-control flag |

## Verification
On every cycle the assertions check that the count falls by one on each returned data quadword, and that a stall blocks reads and freezes the count. They also check that the control bits stay untouched outside idle, that done and interrupt pulses coincide with a cleared start, that addresses stay aligned, and that the stack shifts correctly on push and pop. The following can only be shown by the directed scenarios, each with a known memory image: the exact order of the data addresses along a chain, the next-tag choice for each kind, the stack contents after nested calls, the register state at a pause and the result of resuming, and the forwarding of tags.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
    localparam int QW_LG2 = 4;
    localparam int CTL_START = 8;
    localparam int CTL_TIE   = 7;
    localparam int CTL_TTE   = 6;
    localparam logic [31:0] CTL_MASK   = 32'h0000_01CD;
    localparam logic [1:0]  MODE_CHAIN = 2'd1;

    typedef enum logic [2:0] {
        TAG_REFE = 3'd0, TAG_CNT = 3'd1, TAG_NEXT = 3'd2, TAG_REF = 3'd3,
        TAG_REFS = 3'd4, TAG_CALL = 3'd5, TAG_RET = 3'd6, TAG_END = 3'd7
    } tag_kind_e;

    typedef enum logic [1:0] {ST_IDLE, ST_TAG, ST_DATA} walk_st_e;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0, SEL_MADR = 3'd1, SEL_QWC = 3'd2, SEL_TADR = 3'd3,
        SEL_ASR0 = 3'd4, SEL_ASR1 = 3'd5, SEL_PCE = 3'd6
    } reg_sel_e;
endpackage

// File: rtl/dmaw_tag_decode.sv
module dmaw_tag_decode
    import dmaw_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [CW-1:0] qwc_i,
    input  logic [2:0]    kind_i,
    input  logic [1:0]    pce_act_i,
    input  logic          pause_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] tadr_i,
    input  logic [AW-1:0] stack_top_i,
    input  logic          stack_empty_i,
    output logic [AW-1:0] data_addr_o,
    output logic [AW-1:0] next_tadr_o,
    output logic [AW-1:0] push_addr_o,
    output logic          push_o,
    output logic          pop_o,
    output logic          stop_o,
    output logic          pause_o,
    output logic          pce_set_o,
    output logic          pce_clr_o
);
    localparam logic [AW-1:0] QW_STEP = AW'(1) << QW_LG2;
    localparam logic [AW-1:0] ALIGN   = ~(QW_STEP - AW'(1));

    logic [AW-1:0] field_addr;
    logic [AW-1:0] after_tag;
    logic [AW-1:0] after_data;

    always_comb begin
        field_addr  = addr_i & ALIGN;
        after_tag   = tadr_i + QW_STEP;
        after_data  = after_tag + (AW'(qwc_i) << QW_LG2);
        data_addr_o = after_tag;
        next_tadr_o = after_data;
        push_addr_o = after_data;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        stop_o      = 1'b0;
        pause_o     = pause_i;
        pce_set_o   = (pce_act_i == 2'd3);
        pce_clr_o   = (pce_act_i == 2'd2);
        case (tag_kind_e'(kind_i))
            TAG_REFE: begin
                data_addr_o = field_addr;
                next_tadr_o = after_tag;
                stop_o      = 1'b1;
            end
            TAG_REF, TAG_REFS: begin
                data_addr_o = field_addr;
                next_tadr_o = after_tag;
            end
            TAG_CNT: next_tadr_o = after_data;
            TAG_NEXT: next_tadr_o = field_addr;
            TAG_CALL: begin
                next_tadr_o = field_addr;
                push_o      = 1'b1;
            end
            TAG_RET: begin
                if (stack_empty_i) begin
                    stop_o = 1'b1;
                end else begin
                    next_tadr_o = stack_top_i;
                    pop_o       = 1'b1;
                end
            end
            default: stop_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dmaw_addr_stack.sv
module dmaw_addr_stack #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          wr0_i,
    input  logic          wr1_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] top_o,
    output logic [AW-1:0] second_o,
    output logic          empty_o
);
    localparam int DEPTH = 2;
    localparam int DW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] asr0;
        logic [AW-1:0] asr1;
        logic [DW-1:0] depth;
    } stk_t;

    stk_t q, d;

    always_comb begin
        d = q;
        if (push_i) begin
            d.asr1 = q.asr0;
            d.asr0 = push_addr_i;
            if (q.depth != DW'(DEPTH)) d.depth = q.depth + 1'b1;
        end else if (pop_i) begin
            d.asr0 = q.asr1;
            if (q.depth != '0) d.depth = q.depth - 1'b1;
        end else begin
            if (wr0_i) d.asr0 = wdata_i;
            if (wr1_i) d.asr1 = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign top_o    = q.asr0;
    assign second_o = q.asr1;
    assign empty_o  = (q.depth == '0);

    // R6
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_o == $past(push_addr_i)) && (second_o == $past(top_o)));
    // R6
    pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (top_o == $past(second_o)));
    // R6
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.depth <= DW'(DEPTH));
endmodule

// File: rtl/dma_tag_walker.sv
module dma_tag_walker
    import dmaw_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          chan_en_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_rvalid_i,
    input  logic [127:0]  mem_rdata_i,
    output logic          out_valid_o,
    output logic [127:0]  out_data_o,
    output logic          out_is_tag_o,
    output logic          done_o,
    output logic          irq_o,
    output logic [31:0]   ctrl_o,
    output logic [AW-1:0] madr_o,
    output logic [CW-1:0] qwc_o,
    output logic [AW-1:0] tadr_o,
    output logic [AW-1:0] asr0_o,
    output logic [AW-1:0] asr1_o,
    output logic          pce_o
);
    localparam logic [AW-1:0] QW_STEP = AW'(1) << QW_LG2;
    localparam logic [AW-1:0] ALIGN   = ~(QW_STEP - AW'(1));

    typedef struct packed {
        walk_st_e      st;
        logic [31:0]   ctrl;
        logic [AW-1:0] madr;
        logic [CW-1:0] qwc;
        logic [AW-1:0] tadr;
        logic          pce;
        logic          wait_rd;
        logic          stop;
        logic          pause;
        logic          ovalid;
        logic [127:0]  odata;
        logic          otag;
        logic          done;
        logic          irq;
    } walk_t;

    walk_t q, d;

    logic          stall;
    logic          req;
    logic [AW-1:0] raddr;
    logic [AW-1:0] wr_aligned;
    logic          sw_wr0, sw_wr1;
    logic          stk_push, stk_pop, stk_empty;
    logic [AW-1:0] stk_top, stk_second;
    logic [AW-1:0] dec_data, dec_next, dec_push_addr;
    logic          dec_push, dec_pop, dec_stop, dec_pause, dec_set, dec_clr;

    dmaw_tag_decode #(.AW(AW), .CW(CW)) u_decode (
        .qwc_i        (mem_rdata_i[CW-1:0]),
        .kind_i       (mem_rdata_i[30:28]),
        .pce_act_i    (mem_rdata_i[27:26]),
        .pause_i      (mem_rdata_i[31]),
        .addr_i       (mem_rdata_i[32 +: AW]),
        .tadr_i       (q.tadr),
        .stack_top_i  (stk_top),
        .stack_empty_i(stk_empty),
        .data_addr_o  (dec_data),
        .next_tadr_o  (dec_next),
        .push_addr_o  (dec_push_addr),
        .push_o       (dec_push),
        .pop_o        (dec_pop),
        .stop_o       (dec_stop),
        .pause_o      (dec_pause),
        .pce_set_o    (dec_set),
        .pce_clr_o    (dec_clr)
    );

    dmaw_addr_stack #(.AW(AW)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (stk_push),
        .pop_i      (stk_pop),
        .push_addr_i(dec_push_addr),
        .wr0_i      (sw_wr0),
        .wr1_i      (sw_wr1),
        .wdata_i    (wr_aligned),
        .top_o      (stk_top),
        .second_o   (stk_second),
        .empty_o    (stk_empty)
    );

    always_comb begin
        d          = q;
        d.ovalid   = 1'b0;
        d.otag     = 1'b0;
        d.done     = 1'b0;
        d.irq      = 1'b0;
        req        = 1'b0;
        raddr      = q.tadr;
        stk_push   = 1'b0;
        stk_pop    = 1'b0;
        sw_wr0     = 1'b0;
        sw_wr1     = 1'b0;
        wr_aligned = reg_wdata[AW-1:0] & ALIGN;
        stall      = q.pce && !chan_en_i;
        case (q.st)
            ST_IDLE: begin
                if (reg_we) begin
                    case (reg_sel_e'(reg_sel))
                        SEL_CTRL: d.ctrl = reg_wdata & CTL_MASK;
                        SEL_MADR: d.madr = wr_aligned;
                        SEL_QWC:  d.qwc  = reg_wdata[CW-1:0];
                        SEL_TADR: d.tadr = wr_aligned;
                        SEL_ASR0: sw_wr0 = 1'b1;
                        SEL_ASR1: sw_wr1 = 1'b1;
                        SEL_PCE:  d.pce  = reg_wdata[0];
                        default: ;
                    endcase
                end else if (q.ctrl[CTL_START]) begin
                    if (q.ctrl[3:2] == MODE_CHAIN) begin
                        d.st = ST_TAG;
                    end else if (q.qwc == '0) begin
                        d.ctrl[CTL_START] = 1'b0;
                        d.done            = 1'b1;
                    end else begin
                        d.st    = ST_DATA;
                        d.stop  = 1'b1;
                        d.pause = 1'b0;
                    end
                end
            end
            ST_TAG: begin
                if (q.wait_rd) begin
                    if (mem_rvalid_i) begin
                        d.wait_rd = 1'b0;
                        d.qwc     = mem_rdata_i[CW-1:0];
                        d.madr    = dec_data;
                        d.tadr    = dec_next;
                        d.stop    = dec_stop;
                        d.pause   = dec_pause;
                        if (dec_set)      d.pce = 1'b1;
                        else if (dec_clr) d.pce = 1'b0;
                        stk_push  = dec_push;
                        stk_pop   = dec_pop;
                        d.st      = ST_DATA;
                        if (q.ctrl[CTL_TTE]) begin
                            d.ovalid = 1'b1;
                            d.odata  = mem_rdata_i;
                            d.otag   = 1'b1;
                        end
                    end
                end else if (!stall) begin
                    req       = 1'b1;
                    raddr     = q.tadr;
                    d.wait_rd = 1'b1;
                end
            end
            ST_DATA: begin
                if (q.wait_rd) begin
                    if (mem_rvalid_i) begin
                        d.wait_rd = 1'b0;
                        d.ovalid  = 1'b1;
                        d.odata   = mem_rdata_i;
                        d.madr    = q.madr + QW_STEP;
                        d.qwc     = q.qwc - 1'b1;
                    end
                end else if (q.qwc == '0) begin
                    if (q.stop) begin
                        d.st              = ST_IDLE;
                        d.ctrl[CTL_START] = 1'b0;
                        d.done            = 1'b1;
                    end else if (q.pause) begin
                        d.st              = ST_IDLE;
                        d.ctrl[CTL_START] = 1'b0;
                        d.irq             = q.ctrl[CTL_TIE];
                    end else begin
                        d.st = ST_TAG;
                    end
                end else if (!stall) begin
                    req       = 1'b1;
                    raddr     = q.madr;
                    d.wait_rd = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_req_o    = req;
    assign mem_addr_o   = raddr;
    assign out_valid_o  = q.ovalid;
    assign out_data_o   = q.odata;
    assign out_is_tag_o = q.otag;
    assign done_o       = q.done;
    assign irq_o        = q.irq;
    assign ctrl_o       = q.ctrl;
    assign madr_o       = q.madr;
    assign qwc_o        = q.qwc;
    assign tadr_o       = q.tadr;
    assign asr0_o       = stk_top;
    assign asr1_o       = stk_second;
    assign pce_o        = q.pce;

    // R3
    qwc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && q.wait_rd && mem_rvalid_i)
        |=> (q.qwc == $past(q.qwc) - 1'b1) && out_valid_o);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pce && !chan_en_i && !q.wait_rd) |-> !mem_req_o);
    // R10
    stall_qwc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pce && !chan_en_i && !q.wait_rd && q.st == ST_DATA)
        |=> $stable(q.qwc) && $stable(q.madr));
    // R11
    busy_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.ctrl[7:0]));
    // R2
    done_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ctrl_o[CTL_START]);
    // R8
    irq_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (qwc_o == '0) && !ctrl_o[CTL_START] && !done_o);
    // R4
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (madr_o[QW_LG2-1:0] == '0) && (tadr_o[QW_LG2-1:0] == '0));
endmodule

// File: tb/tb_dma_tag_walker.sv
`timescale 1ns/1ps
module tb_dma_tag_walker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_sel = '0;
    logic [31:0]  reg_wdata = '0;
    logic         chan_en = 1'b1;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_rvalid = 1'b0;
    logic [127:0] mem_rdata = '0;
    logic         out_valid, out_is_tag, done, irq, pce;
    logic [127:0] out_data;
    logic [31:0]  ctrl, madr, tadr, asr0, asr1;
    logic [15:0]  qwc;

    logic [127:0] mem [0:63];
    logic [31:0]  beat_lo [0:31];
    logic         beat_tag [0:31];
    int nbeat = 0, done_cnt = 0, irq_cnt = 0;
    int nvec = 0, nfail = 0;

    always #2.5 clk = ~clk;

    dma_tag_walker dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .chan_en_i(chan_en),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_is_tag_o(out_is_tag),
        .done_o(done), .irq_o(irq), .ctrl_o(ctrl), .madr_o(madr), .qwc_o(qwc),
        .tadr_o(tadr), .asr0_o(asr0), .asr1_o(asr1), .pce_o(pce)
    );

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[9:4]];
        end
    end

    always @(negedge clk) begin
        if (out_valid && nbeat < 32) begin
            beat_lo[nbeat]  = out_data[31:0];
            beat_tag[nbeat] = out_is_tag;
            nbeat++;
        end
        if (done) done_cnt++;
        if (irq)  irq_cnt++;
    end

    function automatic logic [127:0] mk_tag(input logic [2:0] kind, input logic [15:0] n,
                                            input logic [31:0] a, input logic [1:0] act,
                                            input logic pause);
        return {64'h0, a, pause, kind, act, 10'h0, n};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mem_init();
        for (int i = 0; i < 64; i++) mem[i] = {96'h0, 32'(i * 16)};
    endtask

    task automatic clr_log();
        nbeat = 0; done_cnt = 0; irq_cnt = 0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] v);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_stop(input string req);
        int n = 0;
        while (ctrl[8] && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "start cleared", {31'h0, ctrl[8]}, 32'h0);
        repeat (3) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        chk("R1", "ctrl", ctrl, 0);
        chk("R1", "madr", madr, 0);
        chk("R1", "qwc", {16'h0, qwc}, 0);
        chk("R1", "tadr", tadr, 0);
        chk("R1", "asr0", asr0, 0);
        chk("R1", "asr1", asr1, 0);
        chk("R1", "idle outs", {27'h0, pce, mem_req, out_valid, done, irq}, 0);
    endtask

    // R4
    task automatic t_regs();
        wr(3'd0, 32'hFFFF_FEFF); chk("R4", "ctrl mask", ctrl, 32'h0000_00CD);
        wr(3'd1, 32'h5555_AAAA); chk("R4", "madr", madr, 32'h5555_AAA0);
        wr(3'd2, 32'hAAAA_5555); chk("R4", "qwc", {16'h0, qwc}, 32'h5555);
        wr(3'd3, 32'h2AAA_5555); chk("R4", "tadr", tadr, 32'h2AAA_5550);
        wr(3'd4, 32'h1234_5678); chk("R4", "asr0", asr0, 32'h1234_5670);
        wr(3'd5, 32'h8765_432F); chk("R4", "asr1", asr1, 32'h8765_4320);
        wr(3'd6, 32'h1);         chk("R4", "pce set", {31'h0, pce}, 1);
        wr(3'd6, 32'h0);         chk("R4", "pce clr", {31'h0, pce}, 0);
        wr(3'd0, 32'h0);
    endtask

    // R2
    task automatic t_norm_zero();
        clr_log();
        wr(3'd2, 0); wr(3'd1, 32'h0001_2340);
        wr(3'd0, 32'h100);
        wait_stop("R2");
        chk("R2", "qwc", {16'h0, qwc}, 0);
        chk("R2", "madr", madr, 32'h0001_2340);
        chk("R2", "done", done_cnt, 1);
        chk("R2", "no beats", nbeat, 0);
    endtask

    // R3
    task automatic t_norm_three();
        clr_log(); mem_init();
        wr(3'd1, 32'h100); wr(3'd2, 3);
        wr(3'd0, 32'h100);
        wait_stop("R3");
        chk("R3", "beats", nbeat, 3);
        for (int i = 0; i < 3; i++) chk("R3", "beat addr", beat_lo[i], 32'(32'h100 + i * 16));
        chk("R3", "madr", madr, 32'h130);
        chk("R3", "qwc", {16'h0, qwc}, 0);
        chk("R3", "done", done_cnt, 1);
    endtask

    // R5 R6 R7
    task automatic t_chain();
        logic [31:0] e [8] = '{32'h210, 32'h220, 32'h240, 32'h100,
                              32'h120, 32'h130, 32'h330, 32'h350};
        clr_log(); mem_init();
        mem[6'h20] = mk_tag(3'd1, 2, 0, 0, 0);
        mem[6'h23] = mk_tag(3'd2, 1, 32'h300, 0, 0);
        mem[6'h30] = mk_tag(3'd3, 1, 32'h100, 0, 0);
        mem[6'h31] = mk_tag(3'd4, 2, 32'h12F, 0, 0);
        mem[6'h32] = mk_tag(3'd5, 1, 32'h380, 0, 0);
        mem[6'h38] = mk_tag(3'd6, 0, 0, 0, 0);
        mem[6'h34] = mk_tag(3'd7, 1, 0, 0, 0);
        wr(3'd3, 32'h200);
        wr(3'd0, 32'h104);
        wait_stop("R5");
        chk("R5", "beats", nbeat, 8);
        for (int i = 0; i < 8; i++) chk("R5", "chain data addr", beat_lo[i], e[i]);
        chk("R7", "madr after end", madr, 32'h360);
        chk("R7", "tadr after end", tadr, 32'h360);
        chk("R7", "done", done_cnt, 1);
    endtask

    // R8 R9
    task automatic t_suspend();
        clr_log(); mem_init();
        mem[6'h20] = mk_tag(3'd3, 1, 32'h100, 0, 1);
        mem[6'h21] = mk_tag(3'd7, 1, 0, 0, 0);
        wr(3'd3, 32'h200);
        wr(3'd0, 32'h184);
        wait_stop("R8");
        chk("R8", "qwc", {16'h0, qwc}, 0);
        chk("R8", "madr", madr, 32'h110);
        chk("R8", "tadr", tadr, 32'h210);
        chk("R8", "irq pulse", irq_cnt, 1);
        chk("R8", "no done", done_cnt, 0);
        chk("R8", "beat", beat_lo[0], 32'h100);
        wr(3'd0, 32'h184);
        wait_stop("R9");
        chk("R9", "beats", nbeat, 2);
        chk("R9", "resumed data", beat_lo[1], 32'h220);
        chk("R9", "madr", madr, 32'h230);
        chk("R9", "done", done_cnt, 1);
    endtask

    // R6 R7
    task automatic t_stack();
        clr_log(); mem_init();
        mem[6'h28] = mk_tag(3'd5, 0, 32'h2A0, 0, 0);
        mem[6'h2A] = mk_tag(3'd5, 0, 32'h2C0, 0, 0);
        mem[6'h2C] = mk_tag(3'd7, 0, 0, 0, 0);
        wr(3'd3, 32'h280);
        wr(3'd0, 32'h104);
        wait_stop("R6");
        chk("R6", "asr0 newest", asr0, 32'h2B0);
        chk("R6", "asr1 older", asr1, 32'h290);
        chk("R6", "tadr", tadr, 32'h2D0);
        clr_log();
        mem[6'h2E] = mk_tag(3'd6, 0, 0, 0, 0);
        mem[6'h2B] = mk_tag(3'd6, 0, 0, 0, 0);
        mem[6'h29] = mk_tag(3'd6, 0, 0, 0, 0);
        wr(3'd3, 32'h2E0);
        wr(3'd0, 32'h104);
        wait_stop("R7");
        chk("R7", "ret empty tadr", tadr, 32'h2A0);
        chk("R7", "ret empty done", done_cnt, 1);
        chk("R7", "ret empty beats", nbeat, 0);
        clr_log(); mem_init();
        mem[6'h3A] = mk_tag(3'd0, 2, 32'h150, 0, 0);
        wr(3'd3, 32'h3A0);
        wr(3'd0, 32'h104);
        wait_stop("R7");
        chk("R7", "refe beats", nbeat, 2);
        chk("R7", "refe data", beat_lo[1], 32'h160);
        chk("R7", "refe madr", madr, 32'h170);
        chk("R7", "refe tadr", tadr, 32'h3B0);
    endtask

    // R10 R11
    task automatic t_pce();
        clr_log(); mem_init();
        mem[6'h20] = mk_tag(3'd1, 1, 0, 2'd3, 0);
        mem[6'h22] = mk_tag(3'd7, 0, 0, 2'd2, 0);
        chan_en = 1'b0;
        wr(3'd3, 32'h200);
        wr(3'd0, 32'h104);
        repeat (30) @(negedge clk);
        chk("R10", "pce set by tag", {31'h0, pce}, 1);
        chk("R10", "qwc held", {16'h0, qwc}, 1);
        chk("R10", "no beats", nbeat, 0);
        wr(3'd1, 32'h5000);
        chk("R11", "madr write ignored", madr, 32'h210);
        wr(3'd0, 32'h0);
        chk("R11", "ctrl write ignored", ctrl, 32'h104);
        chan_en = 1'b1;
        wait_stop("R10");
        chk("R10", "beats", nbeat, 1);
        chk("R10", "data", beat_lo[0], 32'h210);
        chk("R10", "pce cleared by tag", {31'h0, pce}, 0);
    endtask

    // R12
    task automatic t_tte();
        clr_log(); mem_init();
        mem[6'h20] = mk_tag(3'd7, 1, 0, 0, 0);
        wr(3'd3, 32'h200);
        wr(3'd0, 32'h144);
        wait_stop("R12");
        chk("R12", "beats", nbeat, 2);
        chk("R12", "tag word", beat_lo[0], 32'h7000_0001);
        chk("R12", "tag marker", {31'h0, beat_tag[0]}, 1);
        chk("R12", "data", beat_lo[1], 32'h210);
        chk("R12", "data marker", {31'h0, beat_tag[1]}, 0);
    endtask

    initial begin
        mem_init();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_norm_zero();
        t_norm_three();
        t_chain();
        t_suspend();
        t_stack();
        t_pce();
        t_tte();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule